// File: doc/BRIEF.md
# UART Interrupt Enable and Status Unit

This block gathers thirteen event sources from a UART datapath and turns them into one active-high interrupt line. Each source arrives either as a one-cycle pulse or as a level that stays high while its condition holds. Any cycle in which a source is high sets its status bit. The bit then stays set until software clears it.

Software reaches the block through a word-addressed register bus. There are four registers. A write to the arm register turns on mask bits. A write to the disarm register turns them off. The mask register returns the current mask when read. The status register holds the sticky events and clears bits on a write of one. A status bit raises the interrupt only when its mask bit is on. The interrupt output is registered.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask is zero, every status bit is zero and `irq` is low.
- R2: A write to byte offset 0x08 sets each mask bit whose write-data bit is one. Mask bits written with zero keep their value.
- R3: A write to byte offset 0x0C clears each mask bit whose write-data bit is one. Mask bits written with zero keep their value.
- R4: Reading offset 0x10 returns the mask and reading offset 0x14 returns the status, both in bits 12:0. Reads of 0x08, 0x0C and any unmapped offset return zero.
- R5: A source that is high in a clock cycle sets its status bit at that edge. The bit stays set after the source falls. This includes bit 3 (TX empty), bit 6 (framing) and bit 7 (parity).
- R6: A write to offset 0x14 clears each status bit whose write-data bit is one. Status bits written with zero keep their value.
- R7: If a source is high in the same cycle as a clearing write to its status bit, the bit stays set.
- R8: `irq` equals the OR over all bits of (status AND mask) as it stood one cycle earlier.
- R9: A write to offset 0x10 (read-only mask) changes neither the mask nor the status.
- R10: Write-data bits 31:13 have no effect, and read data bits 31:13 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| addr | input | 8 | Byte offset of the register being read or written |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt | input | 13 | Event sources, bit 0 RX trigger through bit 12 TX overflow |
| irq | output | 1 | Interrupt request, registered, active high |

## Verification
The bench builds the block with its default parameters: thirteen sources, 32-bit data and an 8-bit address. With these values every source bit can be driven one at a time. The write-data bits above the source field can also be driven, so the bench can show that they are dropped. The 8-bit address reaches the unmapped offsets and the read-only mask offset. The bench steps the block through arm and disarm sequences, pulsed and held events, and a clear that lands in the same cycle as an event.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int N_SRC  = 13,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_SRC-1:0]  evt,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_ARM    = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_DISARM = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_MASK   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_STAT   = ADDR_W'(8'h14);

  logic [N_SRC-1:0] mask_q, stat_q;
  logic             irq_q;

  wire [N_SRC-1:0] wbits   = wdata[N_SRC-1:0];
  wire             hit_arm = wr_en && (addr == OFS_ARM);
  wire             hit_dis = wr_en && (addr == OFS_DISARM);
  wire             hit_st  = wr_en && (addr == OFS_STAT);
  wire [N_SRC-1:0] st_clr  = hit_st ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (hit_arm) mask_q <= mask_q | wbits;
    else if (hit_dis) mask_q <= mask_q & ~wbits;
  end

  // a source that is high wins over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~st_clr) | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat_q & mask_q);
  end

  assign irq = irq_q;

  always_comb begin
    case (addr)
      OFS_MASK: rdata = DATA_W'(mask_q);
      OFS_STAT: rdata = DATA_W'(stat_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int N_SRC  = 13,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [N_SRC-1:0]  evt,
  input logic              irq,
  input logic [N_SRC-1:0]  mask,
  input logic [N_SRC-1:0]  stat
);
  a_r2_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h08)) |=>
      ((mask & $past(wdata[N_SRC-1:0])) == $past(wdata[N_SRC-1:0])));

  a_r3_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h0C)) |=> ((mask & $past(wdata[N_SRC-1:0])) == '0));

  a_r5_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(evt)) == $past(evt)));

  a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h14)) |=>
      ((stat & $past(wdata[N_SRC-1:0] & ~evt)) == '0));

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(stat & mask))));

  a_r9_mask_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h10)) |=> $stable(mask));

  a_r4_write_regs_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(8'h08) || addr == ADDR_W'(8'h0C)) |-> (rdata == '0));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .evt(evt), .irq(irq), .mask(mask_q), .stat(stat_q)
);

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [12:0] evt = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  int m_mask = 0, m_stat = 0, m_irq = 0;

  uart_irq_ctrl u_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt(evt), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    int w;
    if (!rst_n) begin
      m_mask = 0; m_stat = 0; m_irq = 0;
    end else begin
      m_irq = ((m_stat & m_mask) != 0) ? 1 : 0;
      w = wr_en ? int'(wdata & 32'h1FFF) : 0;
      if (wr_en && addr == 8'h08) m_mask = m_mask | w;
      if (wr_en && addr == 8'h0C) m_mask = m_mask & ~w;
      if (wr_en && addr == 8'h14) m_stat = m_stat & ~w;
      m_stat = m_stat | int'(evt);
    end
  end

  function automatic int model_read(input logic [7:0] a);
    if (a == 8'h10) return m_mask;
    if (a == 8'h14) return m_stat;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, between edges
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      check("R8 irq vs model", int'(irq), m_irq);
      check("R4 rdata vs model", int'(rdata), model_read(addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, int'(rdata), exp);
  endtask

  task automatic pulse(input logic [12:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h10, 0, "R1 mask after reset");
    rd(8'h14, 0, "R1 status after reset");
    check("R1 irq after reset", int'(irq), 0);

    wr(8'h08, 32'h0000_0005);
    rd(8'h10, 32'h5, "R2 arm bits 0,2");
    wr(8'h08, 32'h0000_1000);
    rd(8'h10, 32'h1005, "R2 arm keeps others");

    wr(8'h0C, 32'h0000_0004);
    rd(8'h10, 32'h1001, "R3 disarm bit 2");
    rd(8'h08, 0, "R4 arm offset reads zero");
    rd(8'h0C, 0, "R4 disarm offset reads zero");
    rd(8'h20, 0, "R4 unmapped offset reads zero");

    wr(8'h10, 32'h0000_1FFF);
    rd(8'h10, 32'h1001, "R9 mask write ignored");
    rd(8'h14, 0, "R9 status untouched");

    wr(8'h08, 32'hFFFF_E000);
    rd(8'h10, 32'h1001, "R10 upper write bits ignored");

    pulse(13'h0008);
    rd(8'h14, 32'h8, "R5 tx empty latched");
    repeat (3) @(negedge clk);
    rd(8'h14, 32'h8, "R5 tx empty stays set");
    check("R8 irq low while masked", int'(irq), 0);

    wr(8'h08, 32'h0000_0008);
    @(negedge clk);
    check("R8 irq high after arming", int'(irq), 1);

    pulse(13'h00C0);
    repeat (2) @(negedge clk);
    rd(8'h14, 32'hC8, "R5 parity and framing stay set");

    wr(8'h14, 32'hFFFF_E008);
    rd(8'h14, 32'hC0, "R6 clear tx empty only");
    rd(8'h14, 32'hC0, "R10 status upper bits read zero");
    @(negedge clk);
    check("R8 irq drops after clear", int'(irq), 0);

    @(negedge clk);
    wr_en = 1'b1; addr = 8'h14; wdata = 32'h40; evt = 13'h0040;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; evt = '0;
    rd(8'h14, 32'hC0, "R7 event wins over clear");
    wr(8'h14, 32'h40);
    rd(8'h14, 32'h80, "R6 framing cleared afterwards");

    @(negedge clk);
    evt = 13'h0001;
    wr(8'h14, 32'h1);
    rd(8'h14, 32'h81, "R7 held level survives clear");
    evt = '0;
    wr(8'h14, 32'h1);
    rd(8'h14, 32'h80, "R6 level bit cleared after release");

    wr(8'h0C, 32'h0000_1FFF);
    rd(8'h10, 0, "R3 disarm all");
    wr(8'h14, 32'h0000_1FFF);
    rd(8'h14, 0, "R6 clear all");
    @(negedge clk);
    check("R8 irq idle at end", int'(irq), 0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule